// File: doc/BRIEF.md
# NAND Chunk Hamming Syndrome Classifier

This block decides what to do with one 512-byte NAND data chunk after it has been read. It receives two 24-bit codes. The first is the 3-byte code kept in the spare area. The second is the 3-byte code that the parity engine produced while the data streamed in. The block spreads each code into a 28-bit word and XORs the two words into a syndrome. A combinational population count over the syndrome then selects one of five verdicts: clean, one correctable data bit, damaged stored code, uncorrectable, or blank (erased) chunk.

The block is used with a start/done handshake. The caller presents both codes and pulses `start` for one cycle. One cycle later `done` pulses and the verdict appears. When the verdict is a correctable bit, the block also gives a byte index and an 8-bit XOR mask. The caller applies that mask to its own copy of the chunk. The verdict stays on the outputs until the next `start`.

Top module: `nand_ecc_syndrome_check`

## Requirements
- R1: A synchronous active-high `rst` drives `done`, `fix_valid`, `status`, `fix_byte` and `fix_mask` to zero on the next clock edge.
- R2: `done` is high in the cycle that follows each cycle in which `start` is sampled high, and low after any cycle in which `start` is low.
- R3: All result outputs change only on a clock edge where `start` is high. Input changes without `start` have no effect on them.
- R4: Each code input carries byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. Each code is unpacked as follows: byte 0 to word bits 7:0, the low nibble of byte 2 to bits 11:8, byte 1 to bits 23:16, and the high nibble of byte 2 to bits 27:24. Word bits 15:12 are zero.
- R5: When the two unpacked words are equal, the syndrome is zero and `status` is 0 (clean).
- R6: A syndrome with exactly 12 bits set gives `status` 1 and raises `fix_valid`. In that case `fix_byte` equals syndrome bits 27:19, and `fix_mask` has only the bit set whose index is syndrome bits 18:16.
- R7: A syndrome with exactly one bit set gives `status` 2 (stored code damaged), and `fix_valid` stays low.
- R8: Every other non-zero syndrome weight (for example 2, 11, 13 or 24) gives `status` 3 (uncorrectable), except the case named in R9.
- R9: A stored code of 0xFFFFFF together with a computed code of 0x000000 gives `status` 4 (blank chunk), and `fix_valid` stays low.
- R10: The blank verdict needs exactly that pair. A stored 0xFFFFFF with any other computed code, or the pair in the reverse order, is classified by weight alone.
- R11: `status` only ever takes the values 0 to 4. Whenever `fix_valid` is low, `fix_byte` and `fix_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Samples both codes and launches a classification |
| stored_code | input | 24 | Code read back from the spare area |
| calc_code | input | 24 | Code recomputed over the data just read |
| done | output | 1 | One-cycle pulse: the result is valid |
| status | output | 3 | Verdict: 0 clean, 1 corrected, 2 code damaged, 3 uncorrectable, 4 blank |
| fix_valid | output | 1 | High when a data bit must be flipped |
| fix_byte | output | 9 | Byte index within the chunk to patch |
| fix_mask | output | 8 | One-hot XOR mask for that byte |

## Verification
The hardest stimulus to produce from the ports is a weight-12 syndrome whose byte index lands on a chosen value, and in particular on the extremes 0 and 511. Such a syndrome needs the twelve high word bits and the twelve low word bits to be complements of each other after unpacking. The vectors were built backwards from a chosen byte index and bit position: the twelve-bit index/position word is split into the high nibble of byte 2 and byte 1, its complement is split into the low nibble of byte 2 and byte 0, and the result is XORed onto an arbitrary stored code. A further weight-12 pattern that does not have that complementary shape checks that the decision rests on weight alone. The blank case and the two near-blank pairs beside it are applied by hand.

// File: rtl/necc_pkg.sv
package necc_pkg;

    // Geometry of one protected chunk and its code
    localparam int CODE_W      = 24;                 // three code bytes
    localparam int SIG_W       = 28;                 // significant unpacked bits
    localparam int BITPOS_W    = 3;                  // bit index within a byte
    localparam int MASK_W      = 1 << BITPOS_W;      // byte width
    localparam int BYTE_W      = 9;                  // byte index within 512
    localparam int BITPOS_LO   = 16;                 // syndrome field start
    localparam int BYTE_LO     = BITPOS_LO + BITPOS_W;
    localparam int CNT_W       = $clog2(SIG_W + 1);
    localparam int CORR_WEIGHT = 12;                 // single data-bit signature
    localparam int CODE_BAD_WEIGHT = 1;

    // Unpacked form of an all-ones stored code
    localparam logic [SIG_W-1:0] BLANK_STORED = 28'hFFF_0FFF;

    typedef enum logic [2:0] {
        RES_CLEAN    = 3'd0,
        RES_FIXED    = 3'd1,
        RES_CODE_BAD = 3'd2,
        RES_MULTI    = 3'd3,
        RES_BLANK    = 3'd4
    } res_e;

    typedef struct packed {
        logic                 done;
        res_e                 status;
        logic                 fix_valid;
        logic [BYTE_W-1:0]    fix_byte;
        logic [MASK_W-1:0]    fix_mask;
    } state_t;

endpackage

// File: rtl/necc_unpack.sv
module necc_unpack
    import necc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [SIG_W-1:0]  word
);
    logic [7:0] b0, b1, b2;

    always_comb begin
        b0 = code[7:0];
        b1 = code[15:8];
        b2 = code[23:16];
        // bits 27:24 <- b2 high nibble, 23:16 <- b1,
        // 15:12 zero, 11:8 <- b2 low nibble, 7:0 <- b0
        word = {b2[7:4], b1, 4'h0, b2[3:0], b0};
    end
endmodule

// File: rtl/necc_popcount.sv
module necc_popcount #(
    parameter int W  = 28,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] acc [0:W];

    assign acc[0] = '0;

    generate
        for (genvar g = 0; g < W; g++) begin : g_sum
            assign acc[g+1] = acc[g] + CW'(din[g]);
        end
    endgenerate

    assign cnt = acc[W];
endmodule

// File: rtl/necc_classify.sv
module necc_classify
    import necc_pkg::*;
(
    input  logic [SIG_W-1:0]  stored_w,
    input  logic [SIG_W-1:0]  calc_w,
    input  logic [SIG_W-1:0]  syn,
    input  logic [CNT_W-1:0]  weight,
    output res_e              status,
    output logic              fix_valid,
    output logic [BYTE_W-1:0] fix_byte,
    output logic [MASK_W-1:0] fix_mask
);
    logic [BITPOS_W-1:0] bitpos;
    logic [MASK_W-1:0]   onehot;
    logic                is_blank;

    assign bitpos   = syn[BITPOS_LO +: BITPOS_W];
    assign is_blank = (stored_w == BLANK_STORED) && (calc_w == '0);

    generate
        for (genvar g = 0; g < MASK_W; g++) begin : g_mask
            assign onehot[g] = (bitpos == BITPOS_W'(g));
        end
    endgenerate

    always_comb begin
        status    = RES_MULTI;
        fix_valid = 1'b0;
        fix_byte  = '0;
        fix_mask  = '0;
        if (syn == '0) begin
            status = RES_CLEAN;
        end else if (weight == CNT_W'(CORR_WEIGHT)) begin
            status    = RES_FIXED;
            fix_valid = 1'b1;
            fix_byte  = syn[BYTE_LO +: BYTE_W];
            fix_mask  = onehot;
        end else if (weight == CNT_W'(CODE_BAD_WEIGHT)) begin
            status = RES_CODE_BAD;
        end else if (is_blank) begin
            status = RES_BLANK;
        end
    end
endmodule

// File: rtl/nand_ecc_syndrome_check.sv
module nand_ecc_syndrome_check
    import necc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [23:0]       stored_code,
    input  logic [23:0]       calc_code,
    output logic              done,
    output logic [2:0]        status,
    output logic              fix_valid,
    output logic [8:0]        fix_byte,
    output logic [7:0]        fix_mask
);
    logic [SIG_W-1:0]  stored_w, calc_w, syn;
    logic [CNT_W-1:0]  weight;
    res_e              cls_status;
    logic              cls_fix_valid;
    logic [BYTE_W-1:0] cls_fix_byte;
    logic [MASK_W-1:0] cls_fix_mask;

    state_t st_d, st_q;

    necc_unpack u_unp_stored (.code(stored_code), .word(stored_w));
    necc_unpack u_unp_calc   (.code(calc_code),   .word(calc_w));

    assign syn = stored_w ^ calc_w;

    necc_popcount #(.W(SIG_W), .CW(CNT_W)) u_pop (
        .din (syn),
        .cnt (weight)
    );

    necc_classify u_cls (
        .stored_w  (stored_w),
        .calc_w    (calc_w),
        .syn       (syn),
        .weight    (weight),
        .status    (cls_status),
        .fix_valid (cls_fix_valid),
        .fix_byte  (cls_fix_byte),
        .fix_mask  (cls_fix_mask)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            st_d.status    = cls_status;
            st_d.fix_valid = cls_fix_valid;
            st_d.fix_byte  = cls_fix_byte;
            st_d.fix_mask  = cls_fix_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done      = st_q.done;
    assign status    = st_q.status;
    assign fix_valid = st_q.fix_valid;
    assign fix_byte  = st_q.fix_byte;
    assign fix_mask  = st_q.fix_mask;

    // ---------------- assertions ----------------
    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(status) && $stable(fix_valid)
                    && $stable(fix_byte) && $stable(fix_mask)));

    assert_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (start && stored_code == calc_code) |=> (status == RES_CLEAN && !fix_valid));

    assert_fix_weight_R6: assert property (@(posedge clk) disable iff (rst)
        (start && weight == CNT_W'(CORR_WEIGHT)) |=> (fix_valid && status == RES_FIXED));

    assert_fix_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        fix_valid |-> ($countones(fix_mask) == 1));

    assert_code_bad_R7: assert property (@(posedge clk) disable iff (rst)
        (start && $countones(stored_code ^ calc_code) == 1)
            |=> (status == RES_CODE_BAD && !fix_valid));

    assert_blank_R9: assert property (@(posedge clk) disable iff (rst)
        (start && stored_code == 24'hFFFFFF && calc_code == 24'h000000)
            |=> (status == RES_BLANK && !fix_valid));

    assert_status_legal_R11: assert property (@(posedge clk) disable iff (rst)
        status <= 3'd4);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !fix_valid |-> (fix_byte == '0 && fix_mask == '0));
endmodule

// File: tb/sim_nand_ecc_syndrome_check.sv
module sim_nand_ecc_syndrome_check;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        done;
    logic [2:0]  status;
    logic        fix_valid;
    logic [8:0]  fix_byte;
    logic [7:0]  fix_mask;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    nand_ecc_syndrome_check u0 (
        .clk(clk), .rst(rst), .start(start),
        .stored_code(stored_code), .calc_code(calc_code),
        .done(done), .status(status), .fix_valid(fix_valid),
        .fix_byte(fix_byte), .fix_mask(fix_mask)
    );

    // {stored, calc, status, byte, mask}
    localparam int NV = 11;
    localparam logic [67:0] VEC [NV] = '{
        {24'h123456, 24'h123456, 3'd0, 9'h000, 8'h00},  // clean
        {24'h3C3C3C, 24'h6617E8, 3'd1, 9'h0A5, 8'h08},  // byte 165 bit 3
        {24'h000000, 24'hF0FF00, 3'd1, 9'h1FF, 8'h80},  // last byte, bit 7
        {24'hA5A5A5, 24'hAAA55A, 3'd1, 9'h000, 8'h01},  // byte 0, bit 0
        {24'h000000, 24'h000FFF, 3'd1, 9'h001, 8'h80},  // weight 12, odd shape
        {24'h000000, 24'h000100, 3'd2, 9'h000, 8'h00},  // weight 1
        {24'hFFFFFF, 24'hFFFF7F, 3'd2, 9'h000, 8'h00},  // weight 1
        {24'h800000, 24'h000000, 3'd2, 9'h000, 8'h00},  // weight 1, top bit
        {24'h111111, 24'h111112, 3'd3, 9'h000, 8'h00},  // weight 2
        {24'h000000, 24'h0007FF, 3'd3, 9'h000, 8'h00},  // weight 11
        {24'hFFFFFF, 24'h000000, 3'd4, 9'h000, 8'h00}   // blank
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Launch one classification; returns at the negedge where done is up
    task automatic apply(input logic [23:0] s, input logic [23:0] c);
        @(negedge clk);
        stored_code = s;
        calc_code   = c;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    function automatic string tag_of(input logic [2:0] st);
        case (st)
            3'd0:    return "R5";
            3'd1:    return "R6 R4";
            3'd2:    return "R7";
            3'd3:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            summary();
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "done",      32'(done),      32'd0);
        chk("R1", "status",    32'(status),    32'd0);
        chk("R1", "fix_valid", 32'(fix_valid), 32'd0);
        chk("R1", "fix_byte",  32'(fix_byte),  32'd0);
        chk("R1", "fix_mask",  32'(fix_mask),  32'd0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [2:0] es;
            es = VEC[i][19:17];
            apply(VEC[i][67:44], VEC[i][43:20]);
            chk("R2", "done", 32'(done), 32'd1);
            chk(tag_of(es), "status",    32'(status),    32'(es));
            chk(tag_of(es), "fix_valid", 32'(fix_valid), 32'(es == 3'd1));
            chk(es == 3'd1 ? "R6 R4" : "R11", "fix_byte", 32'(fix_byte), 32'(VEC[i][16:8]));
            chk(es == 3'd1 ? "R6" : "R11",    "fix_mask", 32'(fix_mask), 32'(VEC[i][7:0]));
            @(negedge clk);
            chk("R2", "done low", 32'(done), 32'd0);
        end

        // R10: near-blank pairs fall back to the weight rule
        apply(24'hFFFFFF, 24'h000001);
        chk("R10", "status one-ones", 32'(status), 32'd3);
        apply(24'h000000, 24'hFFFFFF);
        chk("R10", "status reversed", 32'(status), 32'd3);
        // R8: weight 13
        apply(24'h000000, 24'h001FFF);
        chk("R8", "status weight13", 32'(status), 32'd3);

        // R3: hold while inputs wander without start
        apply(24'h3C3C3C, 24'h6617E8);
        @(negedge clk);
        stored_code = 24'hFFFFFF;
        calc_code   = 24'h000000;
        repeat (3) @(negedge clk);
        chk("R3", "status held",   32'(status),    32'd1);
        chk("R3", "fix_byte held", 32'(fix_byte),  32'h0A5);
        chk("R3", "fix_mask held", 32'(fix_mask),  32'h08);
        chk("R3", "fix_valid held",32'(fix_valid), 32'd1);
        chk("R2", "no done idle",  32'(done),      32'd0);

        // R2/R3: start held on two consecutive cycles
        @(negedge clk);
        stored_code = 24'h555555; calc_code = 24'h555555; start = 1'b1;
        @(negedge clk);
        chk("R2", "b2b done 1",   32'(done),   32'd1);
        chk("R5", "b2b status 1", 32'(status), 32'd0);
        stored_code = 24'h000000; calc_code = 24'h000010;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "b2b done 2",   32'(done),   32'd1);
        chk("R7", "b2b status 2", 32'(status), 32'd2);

        // R1: reset after a corrected result
        apply(24'h000000, 24'hF0FF00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "status after rst",    32'(status),    32'd0);
        chk("R1", "fix_valid after rst", 32'(fix_valid), 32'd0);
        chk("R1", "fix_mask after rst",  32'(fix_mask),  32'd0);
        chk("R1", "fix_byte after rst",  32'(fix_byte),  32'd0);
        chk("R1", "done after rst",      32'(done),      32'd0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule